// File: doc/BRIEF.md
# Serial Escape Sequence Detector

This block watches the byte stream leaving a serial receiver and recognises an escape sequence: one configured character sent a configured number of times in a row, with quiet line time on both sides. Every received byte arrives as a one-cycle strobe with its value. A free-running 24-bit cycle timebase gives the receive time of each byte, and the block keeps the time of the most recent byte. With that timestamp it measures the idle time before the first character, the spacing between characters and the silence after the last one.

The first character only starts a sequence if the line has been quiet for long enough beforehand. Each later character must follow the one before it within the gap limit. Once the required count is reached, the block waits out the post-idle interval. If no byte arrives in that interval, it emits a single-cycle detect pulse. Integration logic outside the block handles masking and clearing of that pulse.

Top module: `escape_seq_detector`

## Requirements
- R1: While reset is asserted, `detectIrq` is low and the match count is zero. After reset, no sequence is in progress.
- R2: A target byte starts a sequence (match count 1) only if the elapsed time since the previous accepted byte is at least `preIdle` cycles. Equality is enough. If no byte has been accepted since reset, the line counts as idle.
- R3: During a sequence, a target byte arriving no more than `gapLimit` cycles after the previous byte adds one to the match count. A target byte arriving later clears the count to zero and does not start a new sequence. The count never jumps by more than one.
- R4: Any accepted byte whose value differs from `escChar` clears the match count to zero.
- R5: Once the count reaches `escCount`, `detectIrq` rises for exactly one clock. That clock directly follows the first cycle in which the elapsed time since the last target byte is at least `postIdle`. A count of one is a legal sequence.
- R6: Any byte accepted while the post-idle wait is pending cancels the detection. This includes a byte sampled in the very cycle in which `postIdle` would have been reached.
- R7: While `escCount` is zero, no sequence is tracked, the match count stays zero and `detectIrq` stays low.
- R8: Elapsed time is the 24-bit difference of timebase values taken modulo 2^24, so a sequence that spans the timebase wrap is judged correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | One-cycle strobe: a received byte is present |
| byteData | input | 8 | Value of the received byte |
| timeNow | input | 24 | Free-running cycle timebase |
| escChar | input | 8 | Character that forms the escape sequence |
| escCount | input | 8 | Number of consecutive characters required; zero disables |
| preIdle | input | 24 | Minimum quiet time before the first character |
| gapLimit | input | 24 | Maximum spacing between consecutive characters |
| postIdle | input | 24 | Quiet time required after the last character |
| detectIrq | output | 1 | One-cycle pulse on a confirmed sequence |

## Verification
The post-idle expiry and the arrival of a new byte can land in the same cycle. When they do, the byte must win and no pulse may follow. The bench provokes this by completing a sequence and then sending a byte whose receive time is exactly `postIdle` cycles after the last escape character. It expects no pulse at all. A companion case sends the byte one cycle later and expects exactly one pulse, which locates the boundary on both sides. The exact-limit cases for the pre-idle and gap windows are also checked one cycle either side of their limits.

// File: rtl/escdet_pkg.sv
`timescale 1ns/1ps
package escdet_pkg;

  // strobes from the sequencing control into the datapath
  typedef struct packed {
    logic loadOne;   // first escape character accepted
    logic bump;      // further escape character accepted
    logic clear;     // drop the match count
    logic fire;      // post-idle met, raise the pulse
  } escCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_POST  = 2'd2
  } escState_e;

endpackage

// File: rtl/escdet_datapath.sv
`timescale 1ns/1ps
module escdet_datapath
  import escdet_pkg::*;
#(
  parameter int TIME_W = 24,
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [CHAR_W-1:0] byteData,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [CHAR_W-1:0] escChar,
  input  logic [CNT_W-1:0]  escCount,
  input  logic [TIME_W-1:0] preIdle,
  input  logic [TIME_W-1:0] gapLimit,
  input  logic [TIME_W-1:0] postIdle,
  input  escCtl_t           ctl,
  output logic              isTarget,
  output logic              preOk,
  output logic              gapOk,
  output logic              postOk,
  output logic              cntHit,
  output logic              enabled,
  output logic [CNT_W-1:0]  matchCnt
);

  localparam int CNT_EXT_W = CNT_W + 1;

  logic [TIME_W-1:0] lastTime;
  logic              seenAny;
  logic [TIME_W-1:0] elapsed;
  logic [CNT_EXT_W-1:0] cntNext;

  // timestamp of the most recent byte, any value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastTime <= '0;
      seenAny  <= 1'b0;
    end else if (byteValid) begin
      lastTime <= timeNow;
      seenAny  <= 1'b1;
    end
  end

  // modular difference handles the timebase wrap
  assign elapsed = timeNow - lastTime;

  assign isTarget = (byteData == escChar);
  assign preOk    = !seenAny || (elapsed >= preIdle);
  assign gapOk    = (elapsed <= gapLimit);
  assign postOk   = (elapsed >= postIdle);
  assign enabled  = (escCount != '0);

  assign cntNext  = {1'b0, matchCnt} + CNT_EXT_W'(1);
  assign cntHit   = (cntNext == {1'b0, escCount});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchCnt <= '0;
    end else if (ctl.clear) begin
      matchCnt <= '0;
    end else if (ctl.loadOne) begin
      matchCnt <= CNT_W'(1);
    end else if (ctl.bump) begin
      matchCnt <= cntNext[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/escdet_control.sv
`timescale 1ns/1ps
module escdet_control
  import escdet_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    byteValid,
  input  logic    isTarget,
  input  logic    preOk,
  input  logic    gapOk,
  input  logic    postOk,
  input  logic    cntHit,
  input  logic    enabled,
  output escCtl_t ctl,
  output logic    detectIrq
);

  escState_e state;
  escState_e stateNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    if (!enabled) begin
      ctl.clear = 1'b1;
      stateNxt  = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (byteValid) begin
            if (isTarget && preOk) begin
              ctl.loadOne = 1'b1;
              stateNxt    = cntHit ? ST_POST : ST_COUNT;
            end else begin
              ctl.clear = 1'b1;
            end
          end
        end
        ST_COUNT: begin
          if (byteValid) begin
            if (isTarget && gapOk) begin
              ctl.bump = 1'b1;
              if (cntHit) stateNxt = ST_POST;
            end else begin
              ctl.clear = 1'b1;
              stateNxt  = ST_IDLE;
            end
          end
        end
        ST_POST: begin
          // a new byte has priority over the expiring wait
          if (byteValid) begin
            ctl.clear = 1'b1;
            stateNxt  = ST_IDLE;
          end else if (postOk) begin
            ctl.fire  = 1'b1;
            ctl.clear = 1'b1;
            stateNxt  = ST_IDLE;
          end
        end
        default: begin
          ctl.clear = 1'b1;
          stateNxt  = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      detectIrq <= 1'b0;
    end else begin
      state     <= stateNxt;
      detectIrq <= ctl.fire;
    end
  end

endmodule

// File: rtl/escape_seq_detector.sv
`timescale 1ns/1ps
module escape_seq_detector
  import escdet_pkg::*;
#(
  parameter int TIME_W = 24,
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [CHAR_W-1:0] byteData,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [CHAR_W-1:0] escChar,
  input  logic [CNT_W-1:0]  escCount,
  input  logic [TIME_W-1:0] preIdle,
  input  logic [TIME_W-1:0] gapLimit,
  input  logic [TIME_W-1:0] postIdle,
  output logic              detectIrq
);

  escCtl_t          ctl;
  logic             isTarget;
  logic             preOk;
  logic             gapOk;
  logic             postOk;
  logic             cntHit;
  logic             enabled;
  logic [CNT_W-1:0] matchCnt;

  escdet_datapath #(
    .TIME_W(TIME_W),
    .CHAR_W(CHAR_W),
    .CNT_W (CNT_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .byteData (byteData),
    .timeNow  (timeNow),
    .escChar  (escChar),
    .escCount (escCount),
    .preIdle  (preIdle),
    .gapLimit (gapLimit),
    .postIdle (postIdle),
    .ctl      (ctl),
    .isTarget (isTarget),
    .preOk    (preOk),
    .gapOk    (gapOk),
    .postOk   (postOk),
    .cntHit   (cntHit),
    .enabled  (enabled),
    .matchCnt (matchCnt)
  );

  escdet_control ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .isTarget (isTarget),
    .preOk    (preOk),
    .gapOk    (gapOk),
    .postOk   (postOk),
    .cntHit   (cntHit),
    .enabled  (enabled),
    .ctl      (ctl),
    .detectIrq(detectIrq)
  );

endmodule

// File: rtl/escdet_checker.sv
`timescale 1ns/1ps
module escdet_checker #(
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic [CHAR_W-1:0] byteData,
  input logic [CHAR_W-1:0] escChar,
  input logic [CNT_W-1:0]  escCount,
  input logic [CNT_W-1:0]  matchCnt,
  input logic              detectIrq
);

  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (!detectIrq && matchCnt == '0)
        else $error("reset state violated");
    end
  end

  // R5
  detect_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    detectIrq |=> !detectIrq);

  // R5
  detect_full_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    detectIrq |-> ($past(matchCnt) == $past(escCount) && $past(escCount) != '0));

  // R6
  byte_blocks_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !detectIrq);

  // R4
  foreign_byte_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteData != escChar) |=> (matchCnt == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (matchCnt == '0 || matchCnt == $past(matchCnt) ||
              matchCnt == CNT_W'($past(matchCnt) + 1'b1)));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (escCount == '0) |=> (!detectIrq && matchCnt == '0));

endmodule

bind escape_seq_detector escdet_checker #(
  .CHAR_W(CHAR_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .byteValid(byteValid),
  .byteData (byteData),
  .escChar  (escChar),
  .escCount (escCount),
  .matchCnt (matchCnt),
  .detectIrq(detectIrq)
);

// File: tb/escape_seq_detector_tb_top.sv
`timescale 1ns/1ps
module escape_seq_detector_tb_top;

  localparam logic [7:0]  ESC  = 8'h2B;
  localparam logic [7:0]  NOISE = 8'h41;
  localparam int          PRE  = 40;
  localparam int          GAP  = 10;
  localparam int          POST = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic [23:0] tick = 24'hFFFFE0;   // starts near the wrap (R8)
  logic [7:0]  escChar = ESC;
  logic [7:0]  escCount = 8'd3;
  logic [23:0] preIdle = 24'(PRE);
  logic [23:0] gapLimit = 24'(GAP);
  logic [23:0] postIdle = 24'(POST);
  logic        detectIrq;

  int nChecks = 0;
  int nFail = 0;
  int detHits = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) tick <= tick + 24'd1;

  always @(negedge clk) if (detectIrq) detHits <= detHits + 1;

  escape_seq_detector dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .byteData (byteData),
    .timeNow  (tick),
    .escChar  (escChar),
    .escCount (escCount),
    .preIdle  (preIdle),
    .gapLimit (gapLimit),
    .postIdle (postIdle),
    .detectIrq(detectIrq)
  );

  task automatic expectEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // byte sampled at exactly one rising edge; returns on the next falling edge
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  // byte whose receive time is 'gap' cycles after the previous byte
  task automatic sendAfter(input int gap, input logic [7:0] b);
    idle(gap - 2);
    sendByte(b);
  endtask

  task automatic hitsSince(input int base, output int n);
    #1;
    n = detHits - base;
  endtask

  // after the last escape byte: silent for POST-1 cycles, pulse, then low
  task automatic postPulseCheck(input string req);
    int base;
    int n;
    base = detHits;
    idle(POST - 1);
    hitsSince(base, n);
    expectEq({req, " no pulse before post-idle"}, n, 0);
    @(negedge clk);
    expectEq({req, " pulse at post-idle"}, int'(detectIrq), 1);
    @(negedge clk);
    expectEq({req, " pulse lasts one cycle"}, int'(detectIrq), 0);
  endtask

  task automatic quietCheck(input string req, input int base);
    int n;
    idle(POST + 30);
    hitsSince(base, n);
    expectEq(req, n, 0);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    idle(3);
    expectEq("R1 detect low in reset", int'(detectIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // R2 idle-since-reset, R3 gap at limit, R5 timing, R8 window spans wrap
  task automatic tBasic();
    sendByte(ESC);
    sendAfter(GAP, ESC);
    sendAfter(5, ESC);
    postPulseCheck("R5 R8 basic");
  endtask

  task automatic tPreShort();
    int base;
    base = detHits;
    sendByte(NOISE);
    sendAfter(PRE - 1, ESC);
    sendAfter(3, ESC);
    sendAfter(3, ESC);
    quietCheck("R2 pre-idle one short", base);
  endtask

  task automatic tPreExact();
    sendByte(NOISE);
    sendAfter(PRE, ESC);
    sendAfter(3, ESC);
    sendAfter(3, ESC);
    postPulseCheck("R2 pre-idle exact");
  endtask

  task automatic tGapLong();
    int base;
    base = detHits;
    sendByte(NOISE);
    sendAfter(PRE, ESC);
    sendAfter(GAP + 1, ESC);
    sendAfter(3, ESC);
    sendAfter(3, ESC);
    quietCheck("R3 gap over limit", base);
  endtask

  task automatic tForeign();
    int base;
    base = detHits;
    sendByte(NOISE);
    sendAfter(PRE, ESC);
    sendAfter(3, ESC);
    sendAfter(3, 8'h5A);
    sendAfter(3, ESC);
    quietCheck("R4 foreign byte mid sequence", base);
  endtask

  task automatic tCancelEdge();
    int base;
    sendByte(NOISE);
    sendAfter(PRE, ESC);
    sendAfter(3, ESC);
    sendAfter(3, ESC);
    base = detHits;
    sendAfter(POST, NOISE);
    quietCheck("R6 byte in expiry cycle", base);
  endtask

  task automatic tCancelLate();
    int base;
    int n;
    sendByte(NOISE);
    sendAfter(PRE, ESC);
    sendAfter(3, ESC);
    sendAfter(3, ESC);
    base = detHits;
    sendAfter(POST + 1, NOISE);
    idle(5);
    hitsSince(base, n);
    expectEq("R6 byte one cycle after expiry", n, 1);
  endtask

  task automatic tDisabled();
    int base;
    escCount = 8'd0;
    base = detHits;
    sendByte(NOISE);
    sendAfter(PRE, ESC);
    quietCheck("R7 zero count disables", base);
    escCount = 8'd3;
  endtask

  task automatic tSingle();
    escCount = 8'd1;
    sendByte(NOISE);
    sendAfter(PRE, ESC);
    postPulseCheck("R5 count of one");
    escCount = 8'd3;
  endtask

  initial begin
    tReset();
    tBasic();
    tPreShort();
    tPreExact();
    tGapLong();
    tForeign();
    tCancelEdge();
    tCancelLate();
    tDisabled();
    tSingle();
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #500000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule